// File: doc/BRIEF.md
# Two-Level Interrupt Priority Resolver

This block arbitrates among six interrupt sources and names the one the processor should service next. The sources are two external lines, timer 0 and timer 1 overflow, a serial source, and a timer-2 source. The serial source is active when either its receive or its transmit flag is set. The timer-2 source is active when either its overflow or its external flag is set. Each source is gated by its own enable and by a global enable. Each source also carries a one-bit priority level, high or low.

The enabled requests are registered once per clock. Arbitration reads the registered set. A high-level request always beats a low-level one. Among requests at the same level, a fixed polling order picks the winner: external 0, timer 0, external 1, timer 1, serial, timer 2. The winner appears as a valid flag, a 3-bit index in polling order, and an 8-bit vector address.

The block keeps one in-service bit per level. The processor pulses `take` to accept the offered request, which marks that request's level as in service. It pulses `reti` on return, which clears the most recently entered level. A request can only preempt a strictly lower level that is in service. A request at the same level can never preempt.

Top module: `irq_prio_resolver`

## Requirements
- R1: After a clock edge with `rst_n` low, `req_valid` is 0 and `busy_lvl` is 2'b00.
- R2: Source i takes part in arbitration only if `glob_en` is 1 and `src_en[i]` is 1. A flag change at the inputs shows at the outputs after exactly one clock edge.
- R3: Source 4 is requested when `src_rx` or `src_tx` is 1. Source 5 is requested when `src_t2ovf` or `src_t2ext` is 1.
- R4: When requests of both levels are eligible, the winner is a request with `src_hi[i]`=1, whatever its index.
- R5: Among eligible requests of the same level, the lowest index wins. The indices are ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, timer2=5.
- R6: While `req_valid` is 1, `req_vec` equals 8'h03 + 8*`req_idx` (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B).
- R7: A `take` pulse while `req_valid` is 1 and `reti` is 0 sets the in-service bit of the winner's level. `busy_lvl[1]` is the high level and `busy_lvl[0]` is the low level.
- R8: While `busy_lvl[1]` is 1, `req_valid` is 0.
- R9: While only `busy_lvl[0]` is 1, low-level requests are ignored and only high-level requests can be offered.
- R10: A `reti` pulse clears `busy_lvl[1]` if it is set, otherwise it clears `busy_lvl[0]`. A `take` in the same cycle as `reti` has no effect.
- R11: A `take` pulse while `req_valid` is 0 leaves `busy_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ext0 | input | 1 | External interrupt 0 flag |
| src_tmr0 | input | 1 | Timer 0 overflow flag |
| src_ext1 | input | 1 | External interrupt 1 flag |
| src_tmr1 | input | 1 | Timer 1 overflow flag |
| src_rx | input | 1 | Serial receive flag |
| src_tx | input | 1 | Serial transmit flag |
| src_t2ovf | input | 1 | Timer 2 overflow flag |
| src_t2ext | input | 1 | Timer 2 external flag |
| glob_en | input | 1 | Global enable for all sources |
| src_en | input | 6 | Per-source enables, indexed in polling order |
| src_hi | input | 6 | Per-source level, 1 = high |
| take | input | 1 | Processor accepts the offered request |
| reti | input | 1 | Return from interrupt |
| req_valid | output | 1 | A request is offered |
| req_idx | output | 3 | Index of the offered source |
| req_vec | output | 8 | Vector address of the offered source |
| busy_lvl | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
A wrong in-service bit shows at the ports on the cycle after the `take` or `reti` that set or cleared it. It appears as a stuck or missing `busy_lvl` bit. It also changes which requests are offered: either all are suppressed, or low-level ones leak past a low service. A wrong registered request or level bit shows one cycle after the inputs change, as a wrong index or a wrong valid flag. The sweeps compare every offered index and vector against a model of the priority rules. They do this for each of the three service states, so a fault cannot stay hidden for more than one sweep step.

// File: rtl/irq_prio_pkg.sv
// Shared constants and helpers for the interrupt priority resolver.
// Assumes source indices follow polling order, index 0 being highest.
package irq_prio_pkg;
    localparam int NSRC     = 6;
    localparam int IDXW     = $clog2(NSRC);
    localparam int VECW     = 8;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;

    // Vector address for a source index.
    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        return VECW'(VEC_BASE + VEC_STEP * int'(idx));
    endfunction
endpackage

// File: rtl/irq_req_sampler.sv
// Registers the enabled request set and the per-source levels once per cycle.
// Assumes raw flags are already synchronous to clk.
module irq_req_sampler #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] lvl_in,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] lvl_q
);
    // Capture masked requests and levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            lvl_q  <= '0;
        end else begin
            pend_q <= glob_en ? (raw & en) : '0;
            lvl_q  <= lvl_in;
        end
    end

    // R2: with the global enable low, nothing is pending next cycle.
    p_glob_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (pend_q == '0));
endmodule

// File: rtl/irq_prio_pick.sv
// Chooses the winning request: level first, then lowest index within level.
// Assumes allow_hi/allow_lo already encode the in-service state.
module irq_prio_pick #(
    parameter int NSRC = 6,
    parameter int IDXW = 3
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] lvl,
    input  logic            allow_hi,
    input  logic            allow_lo,
    output logic            valid,
    output logic [IDXW-1:0] idx,
    output logic            win_hi
);
    localparam int NLVL = 2;

    logic [NSRC-1:0] cand [NLVL];
    logic [NLVL-1:0] any;
    logic [IDXW-1:0] first [NLVL];

    // Per-level candidate mask and lowest-index encoder.
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        always_comb begin
            if (g == 1) cand[g] = allow_hi ? (pend & lvl)  : '0;
            else        cand[g] = allow_lo ? (pend & ~lvl) : '0;
        end
        assign any[g] = |cand[g];
        // Lowest set index of this level's candidates.
        always_comb begin
            first[g] = '0;
            for (int i = NSRC - 1; i >= 0; i--)
                if (cand[g][i]) first[g] = IDXW'(i);
        end
    end

    // Level resolution: high beats low.
    always_comb begin
        valid  = |any;
        win_hi = any[1];
        idx    = any[1] ? first[1] : first[0];
    end
endmodule

// File: rtl/irq_svc_tracker.sv
// Tracks the in-service bit of each priority level.
// Assumes at most two nesting levels: low, then high on top.
module irq_svc_tracker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       reti,
    input  logic       valid,
    input  logic       win_hi,
    output logic [1:0] busy
);
    // Set on accept, clear the top level on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 2'b00;
        end else if (reti) begin
            if (busy[1]) busy[1] <= 1'b0;
            else         busy[0] <= 1'b0;
        end else if (take && valid) begin
            if (win_hi) busy[1] <= 1'b1;
            else        busy[0] <= 1'b1;
        end
    end

    // R7: accepting a high-level winner marks high level in service.
    p_take_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !reti && valid && win_hi) |=> busy[1]);
    // R7: accepting a low-level winner marks low level in service.
    p_take_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !reti && valid && !win_hi) |=> busy[0]);
    // R10: return clears high first, leaving low untouched.
    p_reti_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && busy[1]) |=> (!busy[1] && busy[0] == $past(busy[0])));
    // R11: accept with nothing offered changes nothing.
    p_idle_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !valid && !reti) |=> $stable(busy));
endmodule

// File: rtl/irq_prio_resolver.sv
// Top of the two-level interrupt priority resolver.
// Assumes take/reti are single-cycle pulses from the processor.
module irq_prio_resolver
    import irq_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_ext0,
    input  logic            src_tmr0,
    input  logic            src_ext1,
    input  logic            src_tmr1,
    input  logic            src_rx,
    input  logic            src_tx,
    input  logic            src_t2ovf,
    input  logic            src_t2ext,
    input  logic            glob_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_hi,
    input  logic            take,
    input  logic            reti,
    output logic            req_valid,
    output logic [IDXW-1:0] req_idx,
    output logic [VECW-1:0] req_vec,
    output logic [1:0]      busy_lvl
);
    logic [NSRC-1:0] raw, pend_q, lvl_q;
    logic            win_hi;

    // Merge shared flags into the six sources in polling order.
    always_comb raw = {src_t2ovf | src_t2ext, src_rx | src_tx,
                       src_tmr1, src_ext1, src_tmr0, src_ext0};

    irq_req_sampler #(.NSRC(NSRC)) u_samp (
        .clk(clk), .rst_n(rst_n), .raw(raw), .en(src_en), .glob_en(glob_en),
        .lvl_in(src_hi), .pend_q(pend_q), .lvl_q(lvl_q)
    );

    irq_prio_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
        .pend(pend_q), .lvl(lvl_q),
        .allow_hi(!busy_lvl[1]), .allow_lo(busy_lvl == 2'b00),
        .valid(req_valid), .idx(req_idx), .win_hi(win_hi)
    );

    irq_svc_tracker u_svc (
        .clk(clk), .rst_n(rst_n), .take(take), .reti(reti),
        .valid(req_valid), .win_hi(win_hi), .busy(busy_lvl)
    );

    // Vector lookup for the winner.
    always_comb req_vec = req_valid ? vec_of(req_idx) : '0;

    // R6: vector follows index arithmetically.
    p_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (int'(req_vec) == 3 + 8 * int'(req_idx)));
    // R8: nothing offered during high-level service.
    p_hi_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_lvl[1] |-> !req_valid);
    // R9: during low-level service only high-level winners appear.
    p_lo_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_lvl == 2'b01 && req_valid) |-> win_hi);
    // R4: any eligible high request makes the winner high.
    p_hi_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_lvl[1] && |(pend_q & lvl_q)) |-> (req_valid && win_hi));
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb;
    logic clk = 0, rst_n = 0;
    logic ext0 = 0, tmr0 = 0, ext1 = 0, tmr1 = 0, rx = 0, tx = 0, t2o = 0, t2e = 0;
    logic glob_en = 0, take = 0, reti = 0;
    logic [5:0] src_en = 0, src_hi = 0;
    logic req_valid;
    logic [2:0] req_idx;
    logic [7:0] req_vec;
    logic [1:0] busy_lvl;
    int errors = 0, checks = 0, cycles = 0;

    always #5 clk = ~clk;

    irq_prio_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .src_ext0(ext0), .src_tmr0(tmr0), .src_ext1(ext1),
        .src_tmr1(tmr1), .src_rx(rx), .src_tx(tx), .src_t2ovf(t2o), .src_t2ext(t2e),
        .glob_en(glob_en), .src_en(src_en), .src_hi(src_hi), .take(take), .reti(reti),
        .req_valid(req_valid), .req_idx(req_idx), .req_vec(req_vec), .busy_lvl(busy_lvl)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Expected winner from the priority rules.
    task automatic model(input logic [5:0] pend, input logic [5:0] lvl, input logic [1:0] busy,
                         output logic v, output logic [2:0] ix);
        logic [5:0] hc, lc;
        hc = busy[1] ? 6'b0 : (pend & lvl);
        lc = (busy != 2'b00) ? 6'b0 : (pend & ~lvl);
        v = 0; ix = 0;
        for (int i = 5; i >= 0; i--) if (lc[i]) begin v = 1; ix = 3'(i); end
        if (hc != 0) for (int i = 5; i >= 0; i--) if (hc[i]) begin v = 1; ix = 3'(i); end
    endtask

    // Drive flags at negedge; variant picks which half of each OR pair is used.
    task automatic drive(input logic [5:0] m, input int variant);
        ext0 = m[0]; tmr0 = m[1]; ext1 = m[2]; tmr1 = m[3];
        rx = m[4] && (variant % 3 != 1); tx = m[4] && (variant % 3 != 0);
        t2o = m[5] && (variant % 2 == 0); t2e = m[5] && (variant % 2 == 1);
    endtask

    task automatic step_check(input logic [5:0] m, input logic [5:0] en, input logic [5:0] lvl,
                              input logic g, input logic [1:0] busy, input int variant,
                              input string tag);
        logic v; logic [2:0] ix; logic [7:0] ev;
        @(negedge clk);
        drive(m, variant); src_en = en; src_hi = lvl; glob_en = g;
        @(negedge clk);
        model(g ? (m & en) : 6'b0, lvl, busy, v, ix);
        ev = v ? 8'(3 + 8 * int'(ix)) : 8'h00;
        checks++;
        if (req_valid !== v || (v && (req_idx !== ix || req_vec !== ev))) begin
            errors++;
            $display("FAIL %s: m=%b en=%b lvl=%b g=%0b busy=%b actual v=%0b idx=%0d vec=%h expected v=%0b idx=%0d vec=%h",
                     tag, m, en, lvl, g, busy, req_valid, req_idx, req_vec, v, ix, ev);
        end
    endtask

    task automatic pulse(input logic t, input logic r);
        @(negedge clk); take = t; reti = r;
        @(negedge clk); take = 0; reti = 0;
    endtask

    task automatic chk_busy(input logic [1:0] exp, input string tag);
        checks++;
        if (busy_lvl !== exp) begin
            errors++;
            $display("FAIL %s: actual busy=%b expected busy=%b", tag, busy_lvl, exp);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (req_valid !== 0 || busy_lvl !== 2'b00) begin
            errors++;
            $display("FAIL R1: actual v=%0b busy=%b expected v=0 busy=00", req_valid, busy_lvl);
        end
        rst_n = 1;

        // R4 R5 R6 R3: full sweep of requests and levels, idle service
        for (int m = 0; m < 64; m++)
            for (int l = 0; l < 64; l++)
                step_check(6'(m), 6'h3f, 6'(l), 1'b1, 2'b00, m + l, "R4_R5_R6_R3");

        // R2: enable sweep, global enable low
        for (int e = 0; e < 64; e++) begin
            step_check(6'h3f, 6'(e), 6'b0, 1'b1, 2'b00, e, "R2_en");
            step_check(6'h3f, 6'(e), 6'(e ^ 21), 1'b0, 2'b00, e, "R2_glob");
        end

        // R11: take with nothing offered
        step_check(6'b0, 6'h3f, 6'b0, 1'b1, 2'b00, 0, "R11_idle");
        pulse(1, 0);
        chk_busy(2'b00, "R11");

        // R7 R8: enter high-level service, nothing offered
        step_check(6'b000100, 6'h3f, 6'b000100, 1'b1, 2'b00, 0, "R7_pre");
        pulse(1, 0);
        chk_busy(2'b10, "R7_hi");
        for (int m = 0; m < 64; m++)
            step_check(6'(m), 6'h3f, 6'(m * 5), 1'b1, 2'b10, m, "R8");
        // R10: return from high
        pulse(0, 1);
        chk_busy(2'b00, "R10_hi");

        // R7 R9: low-level service, sweep
        step_check(6'b100000, 6'h3f, 6'b0, 1'b1, 2'b00, 0, "R7_pre_lo");
        pulse(1, 0);
        chk_busy(2'b01, "R7_lo");
        for (int m = 0; m < 64; m++)
            for (int l = 0; l < 64; l += 7)
                step_check(6'(m), 6'h3f, 6'(l), 1'b1, 2'b01, m, "R9");

        // R10: take in same cycle as reti is ignored; nest high on low
        step_check(6'b000010, 6'h3f, 6'b000010, 1'b1, 2'b01, 0, "R9_offer");
        pulse(1, 1);
        chk_busy(2'b00, "R10_take_ignored");
        step_check(6'b000001, 6'h3f, 6'b0, 1'b1, 2'b00, 0, "R5_lo");
        pulse(1, 0);
        chk_busy(2'b01, "R7_lo2");
        step_check(6'b000011, 6'h3f, 6'b000010, 1'b1, 2'b01, 0, "R9_nest");
        pulse(1, 0);
        chk_busy(2'b11, "R7_nest");
        pulse(0, 1);
        chk_busy(2'b01, "R10_pop_hi");
        pulse(0, 1);
        chk_busy(2'b00, "R10_pop_lo");

        // R1: reset clears service state
        pulse(1, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk_busy(2'b00, "R1_rereset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule